// File: doc/BRIEF.md
# Burst Serial Master with Inter-Byte Gap Timing

This block is a clocked-serial master that, once started, moves a run of bytes over SCK, SO and SI without further help. It makes its own serial clock from the system clock. Each byte goes out most significant bit first on SO while the byte coming back on SI is assembled in the same order. The received byte is returned with a one-cycle valid strobe. The next transmit byte is taken from a simple supply port, and a take strobe marks each byte that was consumed.

Between two bytes of a run, SCK rests at its high idle level for a gap. Two independent timers measure the gap: one counts five serial half-periods, which is two and a half serial periods, and one counts a number of system clocks chosen by a 2-bit processing-class input. The next byte begins only once both timers have expired, so the gap is the longer of the two. After the final byte no gap follows: a done pulse appears and the block returns to idle. A synchronous reset abandons any run that is in progress.

Top module: `ser_burst_master`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sck` is 1, `busy` is 0 and `done` is 0. A run interrupted by reset never produces `done` and never drives `sck` low again until a new start.
- R2: Bits leave on `so` most significant first, bit 7 down to bit 0. `so` changes only together with a falling edge of `sck` and is stable while `sck` is high.
- R3: `si` is sampled at each rising edge of `sck`. The first sample becomes bit 7 of `rx_data`. `rx_valid` is high for exactly one cycle after each byte's eighth rising edge, and one receive strobe is given per byte.
- R4: With `half_per` = h (1 or more), `sck` is low for h cycles and then high for h cycles per bit. The low half comes first, and each byte has 8 rising edges.
- R5: Between consecutive bytes of one run, `sck` stays high for max(5·h, N) cycles after the byte's last high half. That last high half lasts h cycles, so the high run measured before the next fall is h + max(5·h, N).
- R6: N is chosen by `proc_class`: 0 gives 14, 1 (multiply) gives 26, 2 (divide) gives 40, 3 (external access with one wait state) gives 18.
- R7: `start` is accepted only while `busy` is 0 and `byte_cnt` is between 1 and 32. In that case the run moves exactly `byte_cnt` bytes. A start with a count of 0 or above 32, or a start while busy, has no effect.
- R8: `done` is high for one cycle, the cycle right after the final byte's last high half-period. In that cycle `busy` is already 0, and no trailing gap comes before it.
- R9: `tx_data` is latched at the start of each byte. `tx_take` is high for one cycle right after the latch, while `sck` is low, and once per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a run |
| byte_cnt | input | 6 | Number of bytes in the run, 1 to 32 |
| half_per | input | 4 | System clocks per serial half-period |
| proc_class | input | 2 | Processing class that selects the system-clock gap count |
| tx_data | input | 8 | Next byte to transmit |
| tx_take | output | 1 | Pulse: `tx_data` was latched |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulse: `rx_data` is new |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Pulse: run finished |
| sck | output | 1 | Serial clock, idles high |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |

## Verification
A wrong phase or half-period count shows on the next `sck` edge as a high or low run of the wrong length, so the error is visible within one bit time. A wrong gap timer or class lookup shows as a wrong high-run length right before the first fall of the next byte. A wrong shift register shows on `so` at the next rising edge, or in `rx_data` one half-period after the byte ends. A wrong byte counter shows when `done` arrives, because the count of rising edges and take strobes no longer matches `byte_cnt`.

// File: rtl/ser_burst_pkg.sv
package ser_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } sbm_state_e;

    localparam int unsigned NEED_PLAIN = 14;
    localparam int unsigned NEED_MUL   = 26;
    localparam int unsigned NEED_DIV   = 40;
    localparam int unsigned NEED_EXTW  = 18;

    localparam int unsigned NEED_MAX_A = (NEED_PLAIN > NEED_MUL) ? NEED_PLAIN : NEED_MUL;
    localparam int unsigned NEED_MAX_B = (NEED_DIV > NEED_EXTW) ? NEED_DIV : NEED_EXTW;
    localparam int unsigned NEED_MAX   = (NEED_MAX_A > NEED_MAX_B) ? NEED_MAX_A : NEED_MAX_B;

    localparam int unsigned GAP_HALVES = 5;

    function automatic int unsigned cyc_need(input logic [1:0] cls);
        case (cls)
            2'd1:    return NEED_MUL;
            2'd2:    return NEED_DIV;
            2'd3:    return NEED_EXTW;
            default: return NEED_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/sbm_half_tick.sv
module sbm_half_tick #(
    parameter int HPW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           clr,
    input  logic [HPW-1:0] hp,
    output logic           tick
);
    logic [HPW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == hp - 1'b1);
        cnt_d = cnt_q + 1'b1;
        if (!run || clr || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sbm_gap_timer.sv
module sbm_gap_timer #(
    parameter int CYC_W  = 6,
    parameter int HALVES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             tick,
    input  logic [CYC_W-1:0] need,
    output logic             expired
);
    localparam int HALF_W = $clog2(HALVES + 1);
    localparam logic [HALF_W-1:0] HALF_TOP = HALF_W'(HALVES);
    localparam logic [CYC_W-1:0]  CYC_TOP  = '1;

    logic [HALF_W-1:0] half_d, half_q;
    logic [CYC_W-1:0]  cyc_d, cyc_q;

    always_comb begin
        half_d = half_q;
        if (tick && half_q < HALF_TOP) begin
            half_d = half_q + 1'b1;
        end
        cyc_d = cyc_q;
        if (cyc_q != CYC_TOP) begin
            cyc_d = cyc_q + 1'b1;
        end
        expired = active && (half_d >= HALF_TOP) && (cyc_d >= need);
        if (!active || expired) begin
            half_d = '0;
            cyc_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= '0;
            cyc_q  <= '0;
        end else begin
            half_q <= half_d;
            cyc_q  <= cyc_d;
        end
    end
endmodule

// File: rtl/ser_burst_master.sv
module ser_burst_master
    import ser_burst_pkg::*;
#(
    parameter int MAXB = 32,
    parameter int HPW  = 4,
    parameter int DW   = 8,
    localparam int CW    = $clog2(MAXB + 1),
    localparam int PW    = $clog2(2 * DW),
    localparam int CYC_W = $clog2(NEED_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CW-1:0]  byte_cnt,
    input  logic [HPW-1:0] half_per,
    input  logic [1:0]     proc_class,
    input  logic [DW-1:0]  tx_data,
    output logic           tx_take,
    output logic [DW-1:0]  rx_data,
    output logic           rx_valid,
    output logic           busy,
    output logic           done,
    output logic           sck,
    output logic           so,
    input  logic           si
);
    localparam logic [PW-1:0] PH_LAST = PW'(2 * DW - 1);

    typedef struct packed {
        sbm_state_e     st;
        logic [PW-1:0]  ph;
        logic [DW-1:0]  sh;
        logic [DW-1:0]  rx;
        logic [DW-1:0]  rxo;
        logic [CW-1:0]  left;
        logic [HPW-1:0] hp;
        logic [1:0]     cls;
        logic           done;
        logic           rxv;
        logic           take;
    } sbm_regs_t;

    sbm_regs_t r_d, r_q;
    logic      tick;
    logic      gap_exp;
    logic      cnt_ok;
    logic [CYC_W-1:0] need;

    assign need   = CYC_W'(cyc_need(r_q.cls));
    assign cnt_ok = (byte_cnt != '0) && (byte_cnt <= CW'(MAXB));

    sbm_half_tick #(.HPW(HPW)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (r_q.st != ST_IDLE),
        .clr  (gap_exp),
        .hp   (r_q.hp),
        .tick (tick)
    );

    sbm_gap_timer #(.CYC_W(CYC_W), .HALVES(GAP_HALVES)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .active  (r_q.st == ST_GAP),
        .tick    (tick),
        .need    (need),
        .expired (gap_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.rxv  = 1'b0;
        r_d.take = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start && cnt_ok) begin
                    r_d.st   = ST_SHIFT;
                    r_d.ph   = '0;
                    r_d.sh   = tx_data;
                    r_d.take = 1'b1;
                    r_d.left = byte_cnt;
                    r_d.hp   = (half_per == '0) ? HPW'(1) : half_per;
                    r_d.cls  = proc_class;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    r_d.ph = r_q.ph + 1'b1;
                    if (!r_q.ph[0]) begin
                        r_d.rx = {r_q.rx[DW-2:0], si};
                    end else if (r_q.ph != PH_LAST) begin
                        r_d.sh = {r_q.sh[DW-2:0], 1'b0};
                    end
                    if (r_q.ph == PH_LAST) begin
                        r_d.rxo = r_q.rx;
                        r_d.rxv = 1'b1;
                        if (r_q.left == CW'(1)) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.left = r_q.left - 1'b1;
                            r_d.st   = ST_GAP;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (gap_exp) begin
                    r_d.st   = ST_SHIFT;
                    r_d.ph   = '0;
                    r_d.sh   = tx_data;
                    r_d.take = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.hp <= HPW'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign sck      = (r_q.st != ST_SHIFT) || r_q.ph[0];
    assign so       = r_q.sh[DW-1];
    assign rx_data  = r_q.rxo;
    assign rx_valid = r_q.rxv;
    assign done     = r_q.done;
    assign tx_take  = r_q.take;
endmodule

// File: rtl/ser_burst_master_chk.sv
module ser_burst_master_chk #(
    parameter int MAXB = 32,
    parameter int CW   = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [CW-1:0] byte_cnt,
    input logic          tx_take,
    input logic          rx_valid,
    input logic          busy,
    input logic          done,
    input logic          sck,
    input logic          so
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (sck && !busy && !done));

    // R1
    idle_sck_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck);

    // R2
    so_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && sck && $past(sck) && $past(busy)) |-> $stable(so));

    // R3
    rxv_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && rx_valid && sck));

    // R8
    done_prev_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R9
    take_low_chk: assert property (@(posedge clk) disable iff (rst)
        tx_take |-> (!sck && busy));

    // R7
    bad_cnt_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (byte_cnt == '0 || byte_cnt > CW'(MAXB))) |=> !busy);
endmodule

bind ser_burst_master ser_burst_master_chk #(.MAXB(MAXB), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .byte_cnt (byte_cnt),
    .tx_take  (tx_take),
    .rx_valid (rx_valid),
    .busy     (busy),
    .done     (done),
    .sck      (sck),
    .so       (so)
);

// File: tb/ser_burst_master_bench.sv
module ser_burst_master_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [5:0] byte_cnt = '0;
    logic [3:0] half_per = 4'd1;
    logic [1:0] proc_class = '0;
    logic [7:0] tx_data;
    logic       tx_take;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       busy;
    logic       done;
    logic       sck;
    logic       so;
    logic       si = 1'b0;

    always #10 clk = ~clk;

    ser_burst_master u_ser_burst_master (
        .clk(clk), .rst(rst), .start(start), .byte_cnt(byte_cnt),
        .half_per(half_per), .proc_class(proc_class), .tx_data(tx_data),
        .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid),
        .busy(busy), .done(done), .sck(sck), .so(so), .si(si)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] txq [32];
    logic [7:0] sv  [32];
    int fall_n = 0, rise_n = 0, take_n = 0, rx_n = 0, hi = 0, lo = 0;
    bit prev_sck = 1'b1;
    bit got_done = 1'b0;
    int done_total = 0;
    int cur_h = 1, cur_gap = 14, cur_n = 1;

    assign tx_data = (take_n < 32) ? txq[take_n] : 8'h00;

    function automatic int need_of(input int c);
        case (c)
            1: return 26;
            2: return 40;
            3: return 18;
            default: return 14;
        endcase
    endfunction

    function automatic int gap_of(input int h, input int c);
        return (5 * h > need_of(c)) ? 5 * h : need_of(c);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_mon();
        fall_n = 0; rise_n = 0; take_n = 0; rx_n = 0;
    endtask

    task automatic step();
        int expv;
        logic exb;
        @(negedge clk);
        got_done = 1'b0;
        if (rst) begin
            clear_mon();
            prev_sck = 1'b1; hi = 0; lo = 0; si = 1'b0;
        end else begin
            if (rx_valid) begin
                chk(rx_n < 32 && rx_data == sv[rx_n], "R3 rx byte", rx_data, sv[rx_n % 32]);
                rx_n++;
            end
            if (tx_take) take_n++;
            if (prev_sck && !sck) begin
                if (fall_n > 0) begin
                    expv = (fall_n % 8 == 0) ? cur_h + cur_gap : cur_h;
                    chk(hi == expv, (fall_n % 8 == 0) ? "R5 R6 gap high run" : "R4 high half", hi, expv);
                end
                si = sv[(fall_n / 8) % 32][7 - fall_n % 8];
                fall_n++;
            end
            if (!prev_sck && sck) begin
                chk(lo == cur_h, "R4 low half", lo, cur_h);
                exb = txq[(rise_n / 8) % 32][7 - rise_n % 8];
                chk(so == exb, "R2 so bit", so, exb);
                rise_n++;
            end
            if (done) begin
                chk(hi == cur_h, "R8 done timing", hi, cur_h);
                chk(!busy, "R8 busy low at done", busy, 0);
                chk(rise_n == 8 * cur_n, "R7 rising edges per run", rise_n, 8 * cur_n);
                chk(take_n == cur_n, "R9 take strobes", take_n, cur_n);
                chk(rx_n == cur_n, "R3 rx strobes", rx_n, cur_n);
                got_done = 1'b1;
                done_total++;
                clear_mon();
            end
            if (sck) begin
                if (!prev_sck) hi = 0;
                hi++;
            end else begin
                if (prev_sck) lo = 0;
                lo++;
            end
            prev_sck = sck;
        end
    endtask

    task automatic run_burst(input int h, input int c, input int n, input bit poke);
        for (int i = 0; i < n; i++) begin
            txq[i] = 8'($urandom);
            sv[i]  = 8'($urandom);
        end
        cur_h = h; cur_gap = gap_of(h, c); cur_n = n;
        half_per = 4'(h); proc_class = 2'(c); byte_cnt = 6'(n);
        start = 1'b1;
        step();
        start = 1'b0; byte_cnt = '0;
        for (int k = 0; k < 20000; k++) begin
            if (poke && k == 20) begin
                start = 1'b1;
                byte_cnt = 6'((n % 32) + 1);
                proc_class = 2'(c + 1);
            end else begin
                start = 1'b0;
                byte_cnt = '0;
            end
            step();
            if (got_done) break;
        end
        start = 1'b0;
        chk(got_done, "R8 done seen", got_done, 1);
        for (int k = 0; k < 3; k++) step();
    endtask

    initial begin
        int unsigned seed_dummy;
        int bad;
        int d0;
        seed_dummy = $urandom(32'h5EED1234);
        for (int i = 0; i < 32; i++) begin txq[i] = '0; sv[i] = '0; end
        rst = 1'b1;
        step(); step();
        chk(sck && !busy && !done, "R1 reset state", {sck, busy, done}, 3'b100);
        rst = 1'b0;
        step();
        chk(sck && !busy && !done, "R1 after reset", {sck, busy, done}, 3'b100);

        // R7: invalid counts ignored
        byte_cnt = 6'd0; start = 1'b1; step(); start = 1'b0; step(); step();
        chk(!busy && sck, "R7 count zero ignored", busy, 0);
        byte_cnt = 6'd33; start = 1'b1; step(); start = 1'b0; byte_cnt = '0; step(); step();
        chk(!busy && sck, "R7 count 33 ignored", busy, 0);

        // R6: each class with a short period so N dominates
        for (int c = 0; c < 4; c++) run_burst(1, c, 2, 1'b0);
        // R5: half-period term dominates, and a tie
        run_burst(10, 2, 2, 1'b0);
        run_burst(8, 2, 2, 1'b0);
        run_burst(6, 0, 3, 1'b0);
        // single byte, and a full 32-byte run
        run_burst(3, 1, 1, 1'b0);
        run_burst(1, 3, 32, 1'b0);

        // random runs, some with a start while busy (R7)
        for (int t = 0; t < 30; t++) begin
            run_burst(1 + int'($urandom % 6), int'($urandom % 4),
                      1 + int'($urandom % 5), bit'($urandom % 2));
        end

        // R1: reset in the middle of a run aborts it
        for (int i = 0; i < 4; i++) begin txq[i] = 8'hA5; sv[i] = 8'h3C; end
        cur_h = 2; cur_gap = gap_of(2, 1); cur_n = 4;
        half_per = 4'd2; proc_class = 2'd1; byte_cnt = 6'd4;
        start = 1'b1; step(); start = 1'b0; byte_cnt = '0;
        for (int k = 0; k < 40; k++) step();
        chk(busy, "R1 run active before reset", busy, 1);
        d0 = done_total;
        rst = 1'b1; step(); rst = 1'b0; step();
        chk(sck && !busy && !done, "R1 abort state", {sck, busy, done}, 3'b100);
        bad = 0;
        for (int k = 0; k < 300; k++) begin
            step();
            if (!sck || busy) bad++;
        end
        chk(bad == 0 && done_total == d0, "R1 no activity after abort", bad, 0);

        // run after abort works
        run_burst(2, 2, 3, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
        $finish;
    end
endmodule